// File: doc/BRIEF.md
# Segment Pixel Register Bank

This block holds the pixel image for a multiplexed segment display. It is an array of sixteen-bit pixel words, four words per common line, plus one sixteen-bit segment-enable word per group of sixteen segments. All of them sit on a simple register bus with an address, write data, a write strobe and combinational read data. A timing controller elsewhere steps through the commons. It presents the index of the active common, and the bank answers with that common's full row of pixel states. Segments that are not enabled as display drivers are forced low in the row.

Pixel writes are only permitted while an external write-allow window is open. A pixel write that arrives while the window is closed is discarded and raises a sticky error flag. Software clears the flag through a status word. The same status word also shows the live state of the write-allow window. Segment-enable writes are never gated by the window.

Top module: `lcdpix_bank`

## Requirements
- R1: A bus write to pixel address a (0 to 31) while write-allow is 1 stores the write data, and a read of address a returns it from the next cycle on.
- R2: Pixel word 4y+j, bit k, is the pixel of segment 16j+k on common y (1 = dark, 0 = clear), and appears on row bit 16j+k when common y is selected.
- R3: Segment-enable word j lives at address 32+j; bit k enables segment 16j+k, drives seg_mask bit 16j+k, and reads back at its address.
- R4: row_data equals the four pixel words of the selected common, concatenated with word 4y in the low bits, ANDed bitwise with seg_mask.
- R5: A pixel write while write-allow is 0 leaves every pixel word unchanged.
- R6: A pixel write while write-allow is 0 sets the error flag. The flag is visible on wr_err and on status bit 0 (address 36) from the next cycle.
- R7: The error flag holds until a bus write to address 36 with bit 0 equal to 0. A write there with bit 0 equal to 1 leaves it set.
- R8: Status bit 1 (address 36) reads the current write-allow input. Writing it has no effect.
- R9: After reset all pixel words, all segment-enable words and the error flag are 0.
- R10: Segment-enable writes take effect whatever the write-allow level, and never set the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| com_sel | input | 3 | Index of the active common |
| wr_allow | input | 1 | Pixel write window open |
| row_data | output | 64 | Pixel row for com_sel, masked by segment enables |
| seg_mask | output | 64 | Segment-enable mask |
| wr_err | output | 1 | Sticky blocked-write error flag |

## Verification
The bench builds the block with its default parameters: eight commons, four words per common and sixteen-bit words. This configuration is small enough to sweep every one of the 32 pixel addresses, all four enable words and all eight commons. Every address is sweeped for stored readback, for blocked writes and for the error set/clear cycle. The row for each common is compared against a bench model under both a full mask and a striped mask. Both window levels are applied to segment-enable and status writes.

// File: rtl/lcdpix_pkg.sv
package lcdpix_pkg;

    typedef enum logic [1:0] {
        REGION_PIXEL  = 2'd0,
        REGION_SEGEN  = 2'd1,
        REGION_STATUS = 2'd2,
        REGION_NONE   = 2'd3
    } region_e;

    localparam int unsigned ERR_BIT   = 0;
    localparam int unsigned ALLOW_BIT = 1;

    function automatic region_e classify(input logic [31:0] a,
                                         input int unsigned n_pix,
                                         input int unsigned n_bank);
        if (a < n_pix)                  return REGION_PIXEL;
        else if (a < n_pix + n_bank)    return REGION_SEGEN;
        else if (a == n_pix + n_bank)   return REGION_STATUS;
        else                            return REGION_NONE;
    endfunction

endpackage

// File: rtl/lcdpix_store.sv
module lcdpix_store #(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned NUM_PIX = 32,
    parameter int unsigned IDX_W   = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [DATA_W-1:0]         wdata,
    input  logic                      allow,
    input  logic                      err_clr,
    output logic [NUM_PIX*DATA_W-1:0] pix_flat,
    output logic                      err_q
);

    logic accept;
    logic blocked;

    assign accept  = wr_en && allow;
    assign blocked = wr_en && !allow;

    for (genvar i = 0; i < NUM_PIX; i++) begin : g_word
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst)
                word_q <= '0;
            else if (accept && (int'(wr_idx) == i))
                word_q <= wdata;
        end
        assign pix_flat[i*DATA_W +: DATA_W] = word_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            err_q <= 1'b0;
        else if (blocked)
            err_q <= 1'b1;
        else if (err_clr)
            err_q <= 1'b0;
    end

    AST_ALLOWED_WRITE_STORES: assert property (@(posedge clk) disable iff (rst)
        accept |=> pix_flat[int'($past(wr_idx))*DATA_W +: DATA_W] == $past(wdata)); // R1

    AST_BLOCKED_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        blocked |=> pix_flat == $past(pix_flat)); // R5

    AST_BLOCKED_WRITE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        blocked |=> err_q); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_q && !err_clr) |=> err_q); // R7

    AST_RESET_CLEARS_ERR: assert property (@(posedge clk)
        rst |=> !err_q); // R9

endmodule

// File: rtl/lcdpix_segen.sv
module lcdpix_segen #(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned NUM_BNK = 4,
    parameter int unsigned IDX_W   = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [DATA_W-1:0]         wdata,
    output logic [NUM_BNK*DATA_W-1:0] mask_flat
);

    for (genvar j = 0; j < NUM_BNK; j++) begin : g_bank
        logic [DATA_W-1:0] en_q;
        always_ff @(posedge clk) begin
            if (rst)
                en_q <= '0;
            else if (wr_en && (int'(wr_idx) == j))
                en_q <= wdata;
        end
        assign mask_flat[j*DATA_W +: DATA_W] = en_q;
    end

    AST_SEGEN_STORES: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mask_flat[int'($past(wr_idx))*DATA_W +: DATA_W] == $past(wdata)); // R10

endmodule

// File: rtl/lcdpix_rowsel.sv
module lcdpix_rowsel #(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned NUM_COM = 8,
    parameter int unsigned PER_COM = 4,
    parameter int unsigned COM_W   = 3
) (
    input  logic [NUM_COM*PER_COM*DATA_W-1:0] pix_flat,
    input  logic [COM_W-1:0]                  com_sel,
    input  logic [PER_COM*DATA_W-1:0]         mask,
    output logic [PER_COM*DATA_W-1:0]         row
);

    localparam int unsigned ROW_W = PER_COM * DATA_W;

    logic [ROW_W-1:0] raw;

    always_comb begin
        raw = '0;
        for (int c = 0; c < NUM_COM; c++) begin
            if (int'(com_sel) == c)
                raw = pix_flat[c*ROW_W +: ROW_W];
        end
    end

    assign row = raw & mask;

endmodule

// File: rtl/lcdpix_bank.sv
module lcdpix_bank
    import lcdpix_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned NUM_COM = 8,
    parameter int unsigned PER_COM = 4,
    localparam int unsigned NUM_PIX = NUM_COM * PER_COM,
    localparam int unsigned NUM_SEG = DATA_W * PER_COM,
    localparam int unsigned ADDR_W  = $clog2(NUM_PIX + PER_COM + 1),
    localparam int unsigned COM_W   = (NUM_COM > 1) ? $clog2(NUM_COM) : 1,
    localparam int unsigned BNK_W   = (PER_COM > 1) ? $clog2(PER_COM) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [COM_W-1:0]  com_sel,
    input  logic              wr_allow,
    output logic [NUM_SEG-1:0] row_data,
    output logic [NUM_SEG-1:0] seg_mask,
    output logic              wr_err
);

    region_e                   region;
    logic [ADDR_W-1:0]         seg_off;
    logic [NUM_PIX*DATA_W-1:0] pix_flat;
    logic                      pix_we;
    logic                      seg_we;
    logic                      err_clr;

    assign region  = classify(32'(bus_addr), NUM_PIX, PER_COM);
    assign seg_off = bus_addr - ADDR_W'(NUM_PIX);
    assign pix_we  = bus_we && (region == REGION_PIXEL);
    assign seg_we  = bus_we && (region == REGION_SEGEN);
    assign err_clr = bus_we && (region == REGION_STATUS) && !bus_wdata[ERR_BIT];

    lcdpix_store #(
        .DATA_W (DATA_W),
        .NUM_PIX(NUM_PIX),
        .IDX_W  (ADDR_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (pix_we),
        .wr_idx  (bus_addr),
        .wdata   (bus_wdata),
        .allow   (wr_allow),
        .err_clr (err_clr),
        .pix_flat(pix_flat),
        .err_q   (wr_err)
    );

    lcdpix_segen #(
        .DATA_W (DATA_W),
        .NUM_BNK(PER_COM),
        .IDX_W  (BNK_W)
    ) u_segen (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (seg_we),
        .wr_idx   (seg_off[BNK_W-1:0]),
        .wdata    (bus_wdata),
        .mask_flat(seg_mask)
    );

    lcdpix_rowsel #(
        .DATA_W (DATA_W),
        .NUM_COM(NUM_COM),
        .PER_COM(PER_COM),
        .COM_W  (COM_W)
    ) u_rowsel (
        .pix_flat(pix_flat),
        .com_sel (com_sel),
        .mask    (seg_mask),
        .row     (row_data)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (region)
            REGION_PIXEL:  bus_rdata = pix_flat[int'(bus_addr)*DATA_W +: DATA_W];
            REGION_SEGEN:  bus_rdata = seg_mask[int'(seg_off[BNK_W-1:0])*DATA_W +: DATA_W];
            REGION_STATUS: begin
                bus_rdata[ERR_BIT]   = wr_err;
                bus_rdata[ALLOW_BIT] = wr_allow;
            end
            default:       bus_rdata = '0;
        endcase
    end

    AST_SEGEN_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (seg_we && !wr_err) |=> !wr_err); // R10

    AST_STATUS_TRACKS_ALLOW: assert property (@(posedge clk) disable iff (rst)
        (region == REGION_STATUS) |-> bus_rdata[ALLOW_BIT] == wr_allow); // R8

endmodule

// File: tb/lcdpix_bank_tb.sv
module lcdpix_bank_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic        bus_we;
    logic [15:0] bus_rdata;
    logic [2:0]  com_sel;
    logic        wr_allow;
    logic [63:0] row_data;
    logic [63:0] seg_mask;
    logic        wr_err;

    int n_chk = 0;
    int n_err = 0;
    logic [15:0] exp_pix [32];
    logic [15:0] exp_en  [4];

    always #4 clk = ~clk;

    lcdpix_bank u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .com_sel(com_sel),
        .wr_allow(wr_allow), .row_data(row_data), .seg_mask(seg_mask),
        .wr_err(wr_err)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [15:0] pat(input int i);
        return 16'((i * 16'h1357) ^ 16'hA5C3);
    endfunction

    function automatic logic [63:0] exp_row(input int c);
        logic [63:0] m;
        m = {exp_en[3], exp_en[2], exp_en[1], exp_en[0]};
        return {exp_pix[4*c+3], exp_pix[4*c+2], exp_pix[4*c+1], exp_pix[4*c]} & m;
    endfunction

    task automatic check_rows(input string req);
        for (int c = 0; c < 8; c++) begin
            com_sel = 3'(c);
            #1;
            chk(req, row_data, exp_row(c));
        end
    endtask

    initial begin
        #1_000_000;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] d;
        rst = 1'b1; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0;
        com_sel = '0; wr_allow = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;

        // R9: everything zero after reset
        for (int a = 0; a < 36; a++) begin
            rd(6'(a), d);
            chk("R9 reg", 64'(d), 64'h0);
        end
        chk("R9 err", 64'(wr_err), 64'h0);
        chk("R9 mask", seg_mask, 64'h0);
        for (int i = 0; i < 32; i++) exp_pix[i] = '0;
        for (int j = 0; j < 4; j++)  exp_en[j] = '0;

        // R1: allowed writes store
        for (int i = 0; i < 32; i++) begin
            wr(6'(i), pat(i));
            exp_pix[i] = pat(i);
        end
        for (int i = 0; i < 32; i++) begin
            rd(6'(i), d);
            chk("R1 readback", 64'(d), 64'(exp_pix[i]));
        end
        check_rows("R4 row with zero mask");

        // R3: enable words, full mask
        for (int j = 0; j < 4; j++) begin
            wr(6'(32 + j), 16'hFFFF);
            exp_en[j] = 16'hFFFF;
        end
        chk("R3 full mask", seg_mask, {64{1'b1}});
        check_rows("R2 row mapping");

        // R3/R4: striped masks
        for (int j = 0; j < 4; j++) begin
            exp_en[j] = 16'(16'hF0F0 >> j) ^ 16'(j * 16'h0101);
            wr(6'(32 + j), exp_en[j]);
        end
        for (int j = 0; j < 4; j++) begin
            rd(6'(32 + j), d);
            chk("R3 enable readback", 64'(d), 64'(exp_en[j]));
        end
        chk("R3 mask port", seg_mask, {exp_en[3], exp_en[2], exp_en[1], exp_en[0]});
        check_rows("R4 masked row");

        // R8: status bit 1 follows allow, not writable
        wr_allow = 1'b0;
        rd(6'd36, d);
        chk("R8 allow low", 64'(d[1]), 64'h0);
        wr(6'd36, 16'h0002);
        rd(6'd36, d);
        chk("R8 write ignored", 64'(d[1]), 64'h0);
        wr_allow = 1'b1;
        rd(6'd36, d);
        chk("R8 allow high", 64'(d[1]), 64'h1);

        // R10: enable write with window closed
        wr_allow = 1'b0;
        exp_en[2] = 16'h5A5A;
        wr(6'd34, 16'h5A5A);
        rd(6'd34, d);
        chk("R10 enable accepted", 64'(d), 64'h5A5A);
        chk("R10 no flag", 64'(wr_err), 64'h0);

        // R5/R6/R7 sweep over every pixel address
        for (int i = 0; i < 32; i++) begin
            wr_allow = 1'b0;
            wr(6'(i), ~exp_pix[i]);
            rd(6'(i), d);
            chk("R5 blocked write", 64'(d), 64'(exp_pix[i]));
            chk("R6 flag set", 64'(wr_err), 64'h1);
            rd(6'd36, d);
            chk("R6 status bit0", 64'(d[0]), 64'h1);
            wr_allow = 1'b1;
            wr(6'd36, 16'h0001);
            repeat (2) @(negedge clk);
            chk("R7 write 1 keeps flag", 64'(wr_err), 64'h1);
            wr(6'd36, 16'h0000);
            chk("R7 write 0 clears", 64'(wr_err), 64'h0);
        end
        check_rows("R5 rows unchanged");

        // R1 again after the window reopens
        exp_pix[13] = 16'h0F0F;
        wr(6'd13, 16'h0F0F);
        rd(6'd13, d);
        chk("R1 write after clear", 64'(d), 64'h0F0F);
        check_rows("R4 final rows");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule